// File: doc/BRIEF.md
# I/O Page Decoder with Boot ROM Overlay

This block sits between an 8-bit sound-processor CPU and its memory. Each CPU access is steered to one of three places: the main RAM, a small bank of control and data registers in the sixteen bytes at 0x00F0–0x00FF, or a 64-byte boot ROM. The boot ROM can be mapped over the top 64 bytes of the address space. That region is 0xFFC0–0xFFFF when `ADDR_W` is 16, and 0x7C0–0x7FF at the default `ADDR_W` of 11. While the ROM is mapped, reads there see ROM contents. Writes there always reach the RAM underneath, so turning the overlay off exposes whatever the CPU stored.

The register page has several jobs. It forwards accesses to a sound DSP through an index/data pair. It holds the timer enables and the three timer period bytes, and it returns the 4-bit timer counters. It also exposes four byte-wide mailbox ports that a host writes. One write-only control byte at 0x00F1 does three things at once: it sets the timer enables, it can clear the mailbox ports in pairs, and it turns the ROM overlay on or off. The timers, the DSP and the CPU are outside this block.

Read data arrives one clock after the address is presented, for every target.

Top module: `iop_decoder`

## Requirements
- R1: After reset the ROM overlay is on, all timer enables are 0, the DSP index is 0, all mailbox ports read 0, and `dsp_we` and `tmr_clr` are low.
- R2: Reads return data on `cpu_rdata` one clock after the address. Addresses outside 0x00F0–0x00FF, and the two scratch bytes 0x00F8 and 0x00F9, behave as plain read/write RAM.
- R3: With the overlay on, reads of the top 64 addresses return ROM bytes. After reset, ROM byte 62 is 0xC0, byte 63 is 0xFF and all other bytes are 0x00. `rom_we` loads the byte at `rom_waddr`. With the overlay off, these reads return RAM.
- R4: CPU writes to the top 64 addresses always update the RAM, whatever the overlay state.
- R5: A write to 0x00F1 loads `tmr_en` from data bits [2:0] one clock later. Data bit 7 sets the overlay on (1) or off (0).
- R6: A write to 0x00F1 with bit 4 set clears the ports at 0x00F4 and 0x00F5; bit 5 set clears 0x00F6 and 0x00F7. A clear takes priority over a host write to the same port in the same cycle.
- R7: 0x00F2 stores an 8-bit DSP index that reads back unchanged. `dsp_addr` is the index's low 7 bits, and a read of 0x00F3 returns `dsp_rdata`.
- R8: A write to 0x00F3 while index bit 7 is 0 pulses `dsp_we` for one clock, one clock later, with `dsp_wdata` equal to the written byte. While index bit 7 is 1, no pulse is produced.
- R9: 0x00F0, 0x00F1 and 0x00FA–0x00FC read as 0x00. CPU writes to 0x00F0 and to 0x00F4–0x00F7 change nothing visible.
- R10: A write to 0x00FA+i loads byte i of `tmr_period`, visible one clock later.
- R11: A read of 0x00FD+i returns nibble i of `tmr_cnt`, zero-extended. Any read or write there pulses `tmr_clr[i]` for one clock, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe (used only for counter clear side effects) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, one clock after the address |
| rom_we | input | 1 | Boot ROM load strobe |
| rom_waddr | input | ROM_AW | Boot ROM load address |
| rom_wdata | input | 8 | Boot ROM load data |
| host_we | input | 1 | Host write to a mailbox port |
| host_sel | input | 2 | Mailbox port select |
| host_wdata | input | 8 | Host mailbox data |
| dsp_addr | output | 7 | DSP register index |
| dsp_rdata | input | 8 | DSP register read value for dsp_addr |
| dsp_we | output | 1 | DSP register write pulse |
| dsp_wdata | output | 8 | DSP register write data |
| tmr_en | output | TMR_N | Timer enables |
| tmr_period | output | 8*TMR_N | Timer period bytes |
| tmr_cnt | input | CNT_W*TMR_N | Timer counter values |
| tmr_clr | output | TMR_N | Timer counter clear pulses |

## Verification
Most internal state is visible at the ports with at most one clock of delay. A wrong overlay flag shows up on the first read of the top 64 bytes, as ROM bytes in place of RAM bytes or the reverse. A lost write-through only shows up after the overlay is turned off. A wrong DSP index shows up at once on `dsp_addr`, and in the next cycle as a missing or spurious `dsp_we` pulse. Mailbox clear errors show up on the next read of 0x00F4–0x00F7. Enable and period errors appear on `tmr_en` and `tmr_period` one clock after the write.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [1:0] {SRC_RAM, SRC_ROM, SRC_REG} rd_src_e;

  localparam logic [3:0] OFF_TEST  = 4'h0;
  localparam logic [3:0] OFF_CTRL  = 4'h1;
  localparam logic [3:0] OFF_IDX   = 4'h2;
  localparam logic [3:0] OFF_DATA  = 4'h3;
  localparam logic [3:0] OFF_PORT0 = 4'h4;
  localparam logic [3:0] OFF_SCR0  = 4'h8;
  localparam logic [3:0] OFF_SCR1  = 4'h9;
  localparam logic [3:0] OFF_PER0  = 4'hA;
  localparam logic [3:0] OFF_CNT0  = 4'hD;

  localparam int CTRL_CLR_LO = 4;
  localparam int CTRL_CLR_HI = 5;
  localparam int CTRL_ROM    = 7;
  localparam int NPORT       = 4;
endpackage

// File: rtl/iop_ram.sv
module iop_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/iop_bootrom.sv
module iop_bootrom #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  // power-up image: zeros, then a vector pointing at the ROM base
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    mem[DEPTH-2] = 8'hC0;
    mem[DEPTH-1] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/iop_regs.sv
module iop_regs
  import iop_pkg::*;
#(
  parameter int TMR_N = 3,
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_sel,
  input  logic [3:0]           io_off,
  input  logic                 we,
  input  logic                 re,
  input  logic [7:0]           wdata,
  input  logic                 host_we,
  input  logic [1:0]           host_sel,
  input  logic [7:0]           host_wdata,
  input  logic [7:0]           dsp_rdata,
  input  logic [CNT_W*TMR_N-1:0] tmr_cnt,
  output logic [7:0]           rd_q,
  output logic [TMR_N-1:0]     tmr_en,
  output logic                 rom_en,
  output logic [7:0]           idx_q,
  output logic                 dsp_we,
  output logic [7:0]           dsp_wdata,
  output logic [8*TMR_N-1:0]   tmr_period,
  output logic [TMR_N-1:0]     tmr_clr
);
  logic wr_hit, rd_hit, ctrl_wr;
  logic [8*NPORT-1:0] port_flat;
  logic [7:0] rd_nxt;

  assign wr_hit  = we && io_sel;
  assign rd_hit  = re && io_sel;
  assign ctrl_wr = wr_hit && (io_off == OFF_CTRL);

  // control, index and DSP forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_en    <= '0;
      rom_en    <= 1'b1;
      idx_q     <= '0;
      dsp_we    <= 1'b0;
      dsp_wdata <= '0;
    end else begin
      dsp_we <= wr_hit && (io_off == OFF_DATA) && !idx_q[7];
      if (wr_hit && (io_off == OFF_DATA) && !idx_q[7]) dsp_wdata <= wdata;
      if (wr_hit && (io_off == OFF_IDX)) idx_q <= wdata;
      if (ctrl_wr) begin
        tmr_en <= wdata[TMR_N-1:0];
        rom_en <= wdata[CTRL_ROM];
      end
    end
  end

  // mailbox ports, cleared in pairs by the control byte
  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic [7:0] pq;
    logic       clr;
    assign clr = ctrl_wr && wdata[(k < 2) ? CTRL_CLR_LO : CTRL_CLR_HI];
    always_ff @(posedge clk) begin
      if (rst || clr) pq <= '0;
      else if (host_we && (host_sel == 2'(k))) pq <= host_wdata;
    end
    assign port_flat[k*8 +: 8] = pq;
  end

  // timer period bytes and counter clear pulses
  for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
    logic [7:0] per_q;
    logic       clr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        per_q <= '0;
        clr_q <= 1'b0;
      end else begin
        clr_q <= (wr_hit || rd_hit) && (io_off == 4'(OFF_CNT0 + i));
        if (wr_hit && (io_off == 4'(OFF_PER0 + i))) per_q <= wdata;
      end
    end
    assign tmr_period[i*8 +: 8] = per_q;
    assign tmr_clr[i] = clr_q;
  end

  // register page read value; unlisted offsets read zero
  always_comb begin
    rd_nxt = '0;
    if (io_off == OFF_IDX)  rd_nxt = idx_q;
    if (io_off == OFF_DATA) rd_nxt = dsp_rdata;
    for (int k = 0; k < NPORT; k++)
      if (io_off == 4'(OFF_PORT0 + k)) rd_nxt = port_flat[k*8 +: 8];
    for (int i = 0; i < TMR_N; i++)
      if (io_off == 4'(OFF_CNT0 + i)) rd_nxt = 8'(tmr_cnt[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end
endmodule

// File: rtl/iop_decoder.sv
module iop_decoder
  import iop_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int ROM_AW = 6,
  parameter int TMR_N  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_we,
  input  logic                     cpu_re,
  input  logic [7:0]               cpu_wdata,
  output logic [7:0]               cpu_rdata,
  input  logic                     rom_we,
  input  logic [ROM_AW-1:0]        rom_waddr,
  input  logic [7:0]               rom_wdata,
  input  logic                     host_we,
  input  logic [1:0]               host_sel,
  input  logic [7:0]               host_wdata,
  output logic [6:0]               dsp_addr,
  input  logic [7:0]               dsp_rdata,
  output logic                     dsp_we,
  output logic [7:0]               dsp_wdata,
  output logic [TMR_N-1:0]         tmr_en,
  output logic [8*TMR_N-1:0]       tmr_period,
  input  logic [CNT_W*TMR_N-1:0]   tmr_cnt,
  output logic [TMR_N-1:0]         tmr_clr
);
  localparam int PAGE_W = ADDR_W - 4;

  logic       io_hit, rom_hit, scratch, ram_we, rom_en;
  logic [7:0] ram_q, rom_q, reg_q, idx_full;
  rd_src_e    src_nxt, src_q;

  assign io_hit  = (cpu_addr[ADDR_W-1:4] == PAGE_W'(8'h0F));
  assign rom_hit = &cpu_addr[ADDR_W-1:ROM_AW];
  assign scratch = (cpu_addr[3:0] == OFF_SCR0) || (cpu_addr[3:0] == OFF_SCR1);
  assign ram_we  = cpu_we && (!io_hit || scratch);

  always_comb begin
    if (io_hit && !scratch)    src_nxt = SRC_REG;
    else if (rom_hit && rom_en) src_nxt = SRC_ROM;
    else                       src_nxt = SRC_RAM;
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_RAM;
    else     src_q <= src_nxt;
  end

  iop_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(cpu_addr), .wdata(cpu_wdata), .rdata(ram_q)
  );

  iop_bootrom #(.AW(ROM_AW)) u_rom (
    .clk(clk), .raddr(cpu_addr[ROM_AW-1:0]), .rdata(rom_q),
    .we(rom_we), .waddr(rom_waddr), .wdata(rom_wdata)
  );

  iop_regs #(.TMR_N(TMR_N), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .io_sel(io_hit), .io_off(cpu_addr[3:0]),
    .we(cpu_we), .re(cpu_re), .wdata(cpu_wdata),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .dsp_rdata(dsp_rdata), .tmr_cnt(tmr_cnt), .rd_q(reg_q),
    .tmr_en(tmr_en), .rom_en(rom_en), .idx_q(idx_full),
    .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
    .tmr_period(tmr_period), .tmr_clr(tmr_clr)
  );

  assign dsp_addr = idx_full[6:0];

  always_comb begin
    case (src_q)
      SRC_ROM: cpu_rdata = rom_q;
      SRC_REG: cpu_rdata = reg_q;
      default: cpu_rdata = ram_q;
    endcase
  end
endmodule

module iop_decoder_chk #(
  parameter int ADDR_W = 11,
  parameter int TMR_N  = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic                 cpu_we,
  input logic                 cpu_re,
  input logic [7:0]           cpu_wdata,
  input logic                 dsp_we,
  input logic [7:0]           dsp_wdata,
  input logic                 idx_msb,
  input logic [TMR_N-1:0]     tmr_en,
  input logic [8*TMR_N-1:0]   tmr_period,
  input logic [TMR_N-1:0]     tmr_clr
);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(8'hF0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'hF1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'hF3);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tmr_en == '0 && !dsp_we && tmr_clr == '0));

  a_r5_enable_load: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == A_CTRL) |=> (tmr_en == $past(cpu_wdata[TMR_N-1:0])));

  a_r8_dsp_forward: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == A_DATA && !idx_msb) |=>
      (dsp_we && dsp_wdata == $past(cpu_wdata)));

  a_r8_dsp_drop: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == A_DATA && idx_msb) |=> !dsp_we);

  a_r8_dsp_cause: assert property (@(posedge clk) disable iff (rst)
    dsp_we |-> $past(cpu_we && cpu_addr == A_DATA));

  a_r9_test_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == A_TEST) |=> $stable(tmr_en));

  for (genvar i = 0; i < TMR_N; i++) begin : g_chk
    a_r10_period_load: assert property (@(posedge clk) disable iff (rst)
      (cpu_we && cpu_addr == ADDR_W'(8'hFA + i)) |=>
        (tmr_period[i*8 +: 8] == $past(cpu_wdata)));

    a_r11_clear_cause: assert property (@(posedge clk) disable iff (rst)
      tmr_clr[i] |-> $past((cpu_we || cpu_re) && cpu_addr == ADDR_W'(8'hFD + i)));
  end
endmodule

bind iop_decoder iop_decoder_chk #(.ADDR_W(ADDR_W), .TMR_N(TMR_N)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
  .cpu_wdata(cpu_wdata), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
  .idx_msb(idx_full[7]), .tmr_en(tmr_en), .tmr_period(tmr_period),
  .tmr_clr(tmr_clr)
);

// File: tb/iop_decoder_tb.sv
`timescale 1ns/100ps
module iop_decoder_tb;
  localparam int ADDR_W = 11;
  localparam int ROM_AW = 6;
  localparam int TMR_N  = 3;
  localparam int CNT_W  = 4;
  localparam int ROM_BASE = (1 << ADDR_W) - (1 << ROM_AW);

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic rom_we = 1'b0;
  logic [ROM_AW-1:0] rom_waddr = '0;
  logic [7:0] rom_wdata = '0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [7:0] host_wdata = '0;
  logic [6:0] dsp_addr;
  logic [7:0] dsp_rdata, dsp_wdata;
  logic dsp_we;
  logic [TMR_N-1:0] tmr_en, tmr_clr;
  logic [8*TMR_N-1:0] tmr_period;
  logic [CNT_W*TMR_N-1:0] tmr_cnt = 12'h9C3;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  assign dsp_rdata = {1'b0, dsp_addr} ^ 8'hA5;

  iop_decoder #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .TMR_N(TMR_N), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rom_we(rom_we),
    .rom_waddr(rom_waddr), .rom_wdata(rom_wdata), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .dsp_addr(dsp_addr),
    .dsp_rdata(dsp_rdata), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
    .tmr_en(tmr_en), .tmr_period(tmr_period), .tmr_cnt(tmr_cnt), .tmr_clr(tmr_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all stimulus changes on the falling edge; results sampled on the next one
  task automatic wr(input int a, input logic [7:0] d);
    cpu_addr = ADDR_W'(a); cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    cpu_addr = ADDR_W'(a); cpu_re = 1'b1;
    @(posedge clk); @(negedge clk);
    d = cpu_rdata; cpu_re = 1'b0;
  endtask

  task automatic host_put(input int k, input logic [7:0] d);
    host_sel = 2'(k); host_wdata = d; host_we = 1'b1;
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic t_reset;
    check(tmr_en == 0, "R1 tmr_en", tmr_en, 0);
    check(!dsp_we && tmr_clr == 0, "R1 pulses", {dsp_we, tmr_clr}, 0);
    rd('hF4, rv); check(rv == 8'h00, "R1 port", rv, 0);
    rd('hF2, rv); check(rv == 8'h00, "R1 index", rv, 0);
    rd(ROM_BASE + 63, rv); check(rv == 8'hFF, "R1 overlay on", rv, 'hFF);
  endtask

  task automatic t_ram;
    wr('h010, 8'hAB); wr('h0EF, 8'hCD); wr('hF8, 8'h12); wr('hF9, 8'h34);
    rd('h010, rv); check(rv == 8'hAB, "R2 low ram", rv, 'hAB);
    rd('h0EF, rv); check(rv == 8'hCD, "R2 below page", rv, 'hCD);
    rd('hF8, rv);  check(rv == 8'h12, "R2 scratch0", rv, 'h12);
    rd('hF9, rv);  check(rv == 8'h34, "R2 scratch1", rv, 'h34);
    wr('h123, 8'h5E);
    rd('h123, rv); check(rv == 8'h5E, "R2 high ram", rv, 'h5E);
  endtask

  task automatic t_overlay;
    rd(ROM_BASE + 62, rv); check(rv == 8'hC0, "R3 vector lo", rv, 'hC0);
    rd(ROM_BASE + 0, rv);  check(rv == 8'h00, "R3 zero byte", rv, 0);
    rom_waddr = 6'd5; rom_wdata = 8'h3C; rom_we = 1'b1;
    @(posedge clk); @(negedge clk); rom_we = 1'b0;
    rd(ROM_BASE + 5, rv); check(rv == 8'h3C, "R3 rom load", rv, 'h3C);
    wr(ROM_BASE + 1, 8'h77);
    rd(ROM_BASE + 1, rv); check(rv == 8'h00, "R3 rom under write", rv, 0);
    wr('hF1, 8'h00);
    rd(ROM_BASE + 1, rv); check(rv == 8'h77, "R4 write-through", rv, 'h77);
    rd(ROM_BASE + 63, rv); check(rv != 8'hFF, "R3 overlay off", rv, 0);
    wr('hF1, 8'h80);
    rd(ROM_BASE + 1, rv); check(rv == 8'h00, "R5 overlay back on", rv, 0);
  endtask

  task automatic t_ctrl;
    wr('hF1, 8'h85);
    check(tmr_en == 3'b101, "R5 enables", tmr_en, 5);
    rd(ROM_BASE + 62, rv); check(rv == 8'hC0, "R5 bit7 on", rv, 'hC0);
    wr('hF0, 8'hFF);
    check(tmr_en == 3'b101, "R9 test write", tmr_en, 5);
    rd(ROM_BASE + 62, rv); check(rv == 8'hC0, "R9 test write rom", rv, 'hC0);
    rd('hF0, rv); check(rv == 0, "R9 read F0", rv, 0);
    rd('hF1, rv); check(rv == 0, "R9 read F1", rv, 0);
  endtask

  task automatic t_ports;
    host_put(0, 8'h11); host_put(1, 8'h22); host_put(2, 8'h33); host_put(3, 8'h44);
    wr('hF4, 8'h99);
    rd('hF4, rv); check(rv == 8'h11, "R9 port write ignored", rv, 'h11);
    rd('hF7, rv); check(rv == 8'h44, "R6 port3", rv, 'h44);
    wr('hF1, 8'h90);
    rd('hF4, rv); check(rv == 0, "R6 clear lo F4", rv, 0);
    rd('hF5, rv); check(rv == 0, "R6 clear lo F5", rv, 0);
    rd('hF6, rv); check(rv == 8'h33, "R6 hi kept", rv, 'h33);
    wr('hF1, 8'hA0);
    rd('hF7, rv); check(rv == 0, "R6 clear hi", rv, 0);
    host_put(2, 8'h66);
    host_sel = 2'd2; host_wdata = 8'h55; host_we = 1'b1;
    wr('hF1, 8'hA0);
    host_we = 1'b0;
    rd('hF6, rv); check(rv == 0, "R6 clear priority", rv, 0);
  endtask

  task automatic t_dsp;
    wr('hF2, 8'h15);
    check(dsp_addr == 7'h15, "R7 dsp_addr", dsp_addr, 'h15);
    rd('hF2, rv); check(rv == 8'h15, "R7 index readback", rv, 'h15);
    rd('hF3, rv); check(rv == 8'hB0, "R7 data read", rv, 'hB0);
    cpu_addr = ADDR_W'('hF3); cpu_wdata = 8'h6E; cpu_we = 1'b1;
    @(posedge clk); @(negedge clk); cpu_we = 1'b0;
    check(dsp_we && dsp_wdata == 8'h6E, "R8 forward", {dsp_we, dsp_wdata}, 'h16E);
    @(posedge clk); @(negedge clk);
    check(!dsp_we, "R8 single pulse", dsp_we, 0);
    wr('hF2, 8'h95);
    wr('hF3, 8'h42);
    check(!dsp_we, "R8 dropped", dsp_we, 0);
    rd('hF2, rv); check(rv == 8'h95, "R7 index bit7", rv, 'h95);
    rd('hF3, rv); check(rv == 8'hB0, "R7 masked index read", rv, 'hB0);
  endtask

  task automatic t_timers;
    wr('hFA, 8'h10); wr('hFB, 8'h20); wr('hFC, 8'h00);
    check(tmr_period == 24'h002010, "R10 periods", tmr_period, 'h002010);
    rd('hFA, rv); check(rv == 0, "R9 read period", rv, 0);
    rd('hFD, rv); check(rv == 8'h03, "R11 cnt0", rv, 3);
    check(tmr_clr == 3'b001, "R11 clr on read", tmr_clr, 1);
    rd('hFF, rv); check(rv == 8'h09, "R11 cnt2", rv, 9);
    wr('hFE, 8'h00);
    check(tmr_clr == 3'b010, "R11 clr on write", tmr_clr, 2);
    @(posedge clk); @(negedge clk);
    check(tmr_clr == 0, "R11 pulse ends", tmr_clr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ram();
    t_overlay();
    t_ctrl();
    t_ports();
    t_dsp();
    t_timers();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule